// File: doc/BRIEF.md
# Dual-Table Configurable Logic Cell

This block is a configurable logic element for a programmable logic fabric. It holds two lookup tables of identical shape. Each table has its own group of K inputs, and that input group addresses one bit of the table's truth table. A dedicated select input picks the output of one of the two tables through a 2-to-1 multiplexer. The picked bit then leaves the cell either directly or through an output register that has a clock enable and a synchronous reset.

Used on its own, each table implements any K-input function. Driving both input groups from the same K signals turns the cell into one (K+1)-input lookup table, with the select as the most significant variable. Loading each table with a 2-to-1 multiplexer pattern turns the whole cell into a 4-to-1 multiplexer. Three cells then make an 8-to-1 multiplexer.

Both tables and the output-mode bit are loaded through a serial shift chain, one bit per clock while the configuration enable is high. The chain's last stage is exposed as a pin, so cells can be daisy-chained.

Top module: `dual_lut_cell`

## Requirements
- R1: With select low, the cell output is bit `lut0_in` of table 0, with `lut0_in[0]` as the least significant address bit.
- R2: With select high, the cell output is bit `lut1_in` of table 1, addressed the same way.
- R3: When both input groups carry the same value v, the output is bit {sel, v} of a 2^(K+1)-bit function. Table 1 holds the upper half of that function and table 0 the lower half.
- R4: While `cfg_en` is high, each clock shifts `cfg_in` into a chain of 2·2^K+1 bits. A full load takes exactly that many clocks. The bits are fed in this order: the output-mode bit, then table 1 from its top bit down to bit 0, then table 0 from its top bit down to bit 0. Table contents do not change while `cfg_en` is low.
- R5: `cfg_out` shows the chain's final stage. After a full load it equals the output-mode bit. Each further shift shows the next bit that was loaded after it.
- R6: With output-mode bit 1, the output follows the multiplexer combinationally, with no clock edge needed.
- R7: With output-mode bit 0, the output is the multiplexer value captured at the last rising edge on which `ce` was high.
- R8: While `ce` is low, the registered output holds its value.
- R9: A low `rst_n` at a rising edge clears the output register to 0. Table contents and the output-mode bit survive reset.
- R10: While `cfg_en` is high, `y` is 0.
- R11: Both tables loaded with 8'hE4 (out = in[0] ? in[2] : in[1]) make the cell a 4-to-1 multiplexer. The data inputs are `lut0_in[1]`, `lut0_in[2]`, `lut1_in[1]` and `lut1_in[2]`. The select is {sel, lut0_in[0]} with `lut1_in[0]` equal to `lut0_in[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Last stage of the configuration chain |
| lut0_in | input | K | Address inputs of table 0 |
| lut1_in | input | K | Address inputs of table 1 |
| sel | input | 1 | Picks table 1 when high, table 0 when low |
| ce | input | 1 | Clock enable of the output register |
| y | output | 1 | Cell output |

## Verification
The hardest situation to reach from the ports is the state of the chain after it has been overrun. Only `cfg_out` shows that state, and only while shifting continues. The stimulus therefore loads a full configuration and keeps `cfg_en` high for two extra clocks. It checks that the mode bit and then the top bits of table 1 appear in turn, and that `y` stays 0 the whole time. Reset retention is reached by building up a registered 1, pulsing reset, and then showing that the unchanged table brings the 1 back on the next enabled edge.

// File: rtl/lcell_pkg.sv
// Package: shared types and sizing helpers for the dual-table logic cell.
// Assumes K >= 1 so each table holds at least two bits.
package lcell_pkg;

    // Output-mode encodings held in the configuration chain's last stage.
    typedef enum logic {
        OUT_REGISTERED    = 1'b0,
        OUT_COMBINATIONAL = 1'b1
    } out_mode_e;

    // Number of truth-table rows for a K-input table.
    function automatic int table_rows(input int k);
        return 1 << k;
    endfunction

endpackage

// File: rtl/cell_lut.sv
// Module: cell_lut
// One K-input lookup table whose contents form a segment of a serial chain.
// New bits enter at row 0 and move toward the top row. The top row is the
// segment's serial output. Contents are not reset; they change only while
// shift_en is high. Assumes K >= 1.
module cell_lut #(
    parameter int K = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         shift_in,
    input  logic [K-1:0] addr,
    output logic         shift_out,
    output logic         rd_bit
);
    import lcell_pkg::*;

    localparam int ROWS = table_rows(K);

    logic [ROWS-1:0] rows_q;

    // Shift the truth table by one row while configuration is active.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            rows_q <= {rows_q[ROWS-2:0], shift_in};
        end
    end

    // Read the row addressed by the input group.
    always_comb begin
        rd_bit    = rows_q[addr];
        shift_out = rows_q[ROWS-1];
    end

    // R4: the incoming serial bit lands in row 0.
    assert_shift_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (rows_q[0] == $past(shift_in)));

    // R4: contents hold while configuration is idle.
    assert_table_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(rows_q));

endmodule

// File: rtl/cell_out_stage.sv
// Module: cell_out_stage
// Picks one of two table bits, optionally registers the result, and drives
// the cell output. The register has a clock enable and a synchronous
// active-low clear. The output is forced low during configuration.
module cell_out_stage (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  logic                 cfg_en,
    input  lcell_pkg::out_mode_e mode,
    input  logic                 bit0,
    input  logic                 bit1,
    input  logic                 sel,
    output logic                 y
);
    import lcell_pkg::*;

    logic pick;
    logic q;

    // Two-way choice between the table outputs.
    always_comb begin
        pick = sel ? bit1 : bit0;
    end

    // Output register: clear on reset, capture when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (ce) begin
            q <= pick;
        end
    end

    // Output select: quiet during configuration, else bypass or register.
    always_comb begin
        if (cfg_en) begin
            y = 1'b0;
        end else if (mode == OUT_COMBINATIONAL) begin
            y = pick;
        end else begin
            y = q;
        end
    end

    // R9: reset clears the register by the following cycle.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (q == 1'b0));

    // R8: register holds while the clock enable is low.
    assert_ce_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(q));

    // R7: register captures the chosen table bit on an enabled edge.
    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> (q == $past(pick)));

endmodule

// File: rtl/dual_lut_cell.sv
// Module: dual_lut_cell (top)
// Configurable logic cell: two K-input tables, a select-driven 2-to-1 choice
// and an optional output register. The configuration chain runs
// cfg_in -> table 0 -> table 1 -> output-mode bit -> cfg_out. With the mode
// bit fed first, it ends in the last stage. Configuration is not reset.
module dual_lut_cell #(
    parameter int K = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_in,
    output logic         cfg_out,
    input  logic [K-1:0] lut0_in,
    input  logic [K-1:0] lut1_in,
    input  logic         sel,
    input  logic         ce,
    output logic         y
);
    import lcell_pkg::*;

    localparam int NUM_TABLES = 2;

    logic [NUM_TABLES:0]   link;
    logic [NUM_TABLES-1:0] tbl_bit;
    logic [K-1:0]          tbl_addr [NUM_TABLES];
    out_mode_e             mode_q;

    always_comb begin
        link[0]     = cfg_in;
        tbl_addr[0] = lut0_in;
        tbl_addr[1] = lut1_in;
    end

    // One table per chain segment, chained in index order.
    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_table
        cell_lut #(.K(K)) u_lut (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_en  (cfg_en),
            .shift_in  (link[t]),
            .addr      (tbl_addr[t]),
            .shift_out (link[t+1]),
            .rd_bit    (tbl_bit[t])
        );
    end

    // Output-mode bit: last stage of the configuration chain.
    always_ff @(posedge clk) begin
        if (cfg_en) begin
            mode_q <= out_mode_e'(link[NUM_TABLES]);
        end
    end

    always_comb begin
        cfg_out = mode_q;
    end

    cell_out_stage u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce     (ce),
        .cfg_en (cfg_en),
        .mode   (mode_q),
        .bit0   (tbl_bit[0]),
        .bit1   (tbl_bit[1]),
        .sel    (sel),
        .y      (y)
    );

    // R5: the chain tail takes the top row of table 1 on each shift.
    assert_chain_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_out == $past(link[NUM_TABLES])));

    // R10: the output stays low during configuration.
    assert_cfg_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (y == 1'b0));

endmodule

// File: tb/test_dual_lut_cell.sv
// Bench for dual_lut_cell: a table of vectors walked by one loop, then
// directed tests for chain order, register modes, reset and multiplexing.
module test_dual_lut_cell;

    localparam int CLK_PERIOD = 10;
    localparam int K          = 3;

    // Vector fields: [7] sel, [6:4] lut0_in, [3:1] lut1_in, [0] expected y.
    // Table 0 = 8'hE8, table 1 = 8'h96, combinational mode.
    localparam logic [7:0] VECS [12] = '{
        8'h3D, 8'h51, 8'h0E, 8'h46, 8'h71, 8'h1A,
        8'h83, 8'hF6, 8'hA9, 8'h8F, 8'hD0, 8'hBC
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_en = 1'b0;
    logic         cfg_in = 1'b0;
    logic         cfg_out;
    logic [K-1:0] lut0_in = '0;
    logic [K-1:0] lut1_in = '0;
    logic         sel = 1'b0;
    logic         ce = 1'b0;
    logic         y;

    int n_checks = 0;
    int n_errors = 0;

    dual_lut_cell #(.K(K)) i_dual_lut_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_in  (cfg_in),
        .cfg_out (cfg_out),
        .lut0_in (lut0_in),
        .lut1_in (lut1_in),
        .sel     (sel),
        .ce      (ce),
        .y       (y)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Feed mode bit, table 1 (top row first), then table 0 (top row first).
    task automatic load_cfg(input logic mode, input logic [7:0] t1,
                            input logic [7:0] t0, input logic keep_en);
        logic [16:0] stream;
        stream = {mode, t1, t0};
        for (int i = 16; i >= 0; i--) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_in = stream[i];
            if (i == 8) begin
                #1 check("R10 output low mid-load", y, 1'b0);
            end
        end
        @(negedge clk);
        if (!keep_en) cfg_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: vector walk with separate input groups.
        load_cfg(1'b1, 8'h96, 8'hE8, 1'b0);
        foreach (VECS[v]) begin
            @(negedge clk);
            sel     = VECS[v][7];
            lut0_in = VECS[v][6:4];
            lut1_in = VECS[v][3:1];
            #1 check(VECS[v][7] ? "R2 table 1 lookup" : "R1 table 0 lookup",
                     y, VECS[v][0]);
        end

        // R3: shared inputs form a 16-row function, select as top bit.
        load_cfg(1'b1, 8'hC3, 8'hA5, 1'b0);
        for (int idx = 0; idx < 16; idx++) begin
            @(negedge clk);
            lut0_in = idx[2:0];
            lut1_in = idx[2:0];
            sel     = idx[3];
            #1 check("R3 wide function", y, 16'hC3A5 >> idx);
        end

        // R11: both tables as 2-to-1 muxes give a 4-to-1 mux.
        load_cfg(1'b1, 8'hE4, 8'hE4, 1'b0);
        for (int p = 0; p < 2; p++) begin
            logic [3:0] d;
            d = (p == 0) ? 4'b0110 : 4'b1001;
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                lut0_in = {d[1], d[0], s[0]};
                lut1_in = {d[3], d[2], s[0]};
                sel     = s[1];
                #1 check("R11 four-way mux", y, d[s]);
            end
        end

        // R7: registered mode, table 0 = 8'hF0 (1 for rows 4..7).
        load_cfg(1'b0, 8'h00, 8'hF0, 1'b0);
        sel = 1'b0; lut0_in = 3'd0; ce = 1'b1;
        @(negedge clk);
        lut0_in = 3'd4;
        #1 check("R7 no change before edge", y, 1'b0);
        @(posedge clk);
        #1 check("R7 captured on edge", y, 1'b1);

        // R8: clock enable low holds the register.
        @(negedge clk);
        ce = 1'b0; lut0_in = 3'd0;
        @(posedge clk);
        #1 check("R8 hold with ce low", y, 1'b1);

        // R9: reset clears the register and keeps the tables.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 check("R9 reset clears output", y, 1'b0);
        @(negedge clk);
        rst_n = 1'b1; ce = 1'b1; lut0_in = 3'd4;
        @(posedge clk);
        #1 check("R9 table kept over reset", y, 1'b1);

        // R6: combinational mode follows inputs without an edge.
        load_cfg(1'b1, 8'h00, 8'hF0, 1'b0);
        ce = 1'b0;
        @(negedge clk);
        lut0_in = 3'd5;
        #1 check("R6 bypass follows high", y, 1'b1);
        #2 lut0_in = 3'd1;
        #1 check("R6 bypass follows low", y, 1'b0);

        // R5/R4: chain order observed at cfg_out, with overrun shifts.
        load_cfg(1'b1, 8'h5A, 8'h00, 1'b1);
        #1 check("R5 mode bit at chain tail", cfg_out, 1'b1);
        check("R10 output low while enabled", y, 1'b0);
        cfg_in = 1'b0;
        @(posedge clk);
        #1 check("R4 table 1 top row next", cfg_out, 1'b0);
        @(posedge clk);
        #1 check("R4 table 1 second row next", cfg_out, 1'b1);
        check("R10 output low during overrun", y, 1'b0);
        @(negedge clk);
        cfg_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule